// File: doc/BRIEF.md
# Banked Memory Array

This block builds one addressable memory out of several identical storage banks. Each bank holds 256 words of 8 bits. A decoder on the upper address bits produces the chip enable of each bank, so the storage grows by adding banks rather than by declaring one large array.

A build-time parameter picks one of two organizations for four banks:

- **Depth organization:** 1024 words of 8 bits. The low eight address bits reach every bank, and the two upper bits pick one bank.
- **Width organization:** 512 words of 16 bits. Two groups of two banks work side by side. Address bit 8 picks the group. Inside a group, lane 1 holds data bits 15:8 and lane 0 holds bits 7:0.

The bus side has an active-low chip enable and an active-low write enable. It has separate write-data and read-data buses in place of a shared bidirectional bus. Writes land on the rising clock edge. Reads are combinational and come from the addressed word.

Top module: `bmem_top`

## Requirements
- R1: In depth organization the address is 10 bits wide. Bits 9:8 choose the bank and bits 7:0 choose the word inside it. A word written at any address reads back unchanged from that address.
- R2: Exactly one bank group is enabled by an active access. Addresses that share their low eight bits but differ in the upper bits are separate words. For example, address 717 maps to bank 2, word 205. Writing it leaves addresses 205, 461 and 973 unchanged.
- R3: A write updates the memory at the rising clock edge. A read of the same address in the following cycle returns the new word.
- R4: A write happens only when chip enable (low) and write enable (low) are both asserted. With chip enable high, a low write enable changes nothing.
- R5: While chip enable is high, read data is all zeros and the valid flag is low.
- R6: During a write access, read data is all zeros and the valid flag is low.
- R7: During a read access (chip enable low, write enable high), the valid flag is high. Read data equals the word last written at that address, with no clock delay.
- R8: In width organization the address is 9 bits wide and bit 8 chooses the bank group. Each access writes or reads all 16 bits together, with bits 15:8 and 7:0 held in the two banks of the group.
- R9: Words at bank and group boundaries keep their own contents. In depth organization these are addresses 255/256, 511/512, 767/768 and 1023. In width organization they are 255/256 and 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes land on its rising edge |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W (10 depth, 9 width) | Word address |
| wdata_i | input | DATA_W (8 depth, 16 width) | Write data |
| rdata_o | output | DATA_W | Read data, zero unless a read access is active |
| rvalid_o | output | 1 | High during a read access |

## Verification
The hardest case to reach from the ports is aliasing between banks. A decode fault that enables the wrong bank, or more than one bank, still reads back correctly whenever only one alias of a word has ever been written. To expose it, the stimulus first fills the entire memory with a pattern whose value depends on the upper address bits. It then writes distinct words to all four aliases of local word 205 and reads each one back. A second hard case is a low write enable while the chip is disabled. The bench drives exactly that combination with fresh data, then reads the address to show the old word survived.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    // Storage organization of the bank set
    typedef enum logic {
        ORG_DEPTH = 1'b0,   // banks stacked: more words, bank width
        ORG_WIDTH = 1'b1    // banks paired: fewer words, double width
    } org_e;

    // Number of banks that sit side by side to form one word
    function automatic int lanes_of(org_e org);
        return (org == ORG_WIDTH) ? 2 : 1;
    endfunction

endpackage

// File: rtl/bmem_bank.sv
module bmem_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          cs_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] store [WORDS];

    // Write only when selected and write enable asserted
    always_ff @(posedge clk_i) begin
        if (!cs_n_i && !we_n_i) begin
            store[addr_i] <= wdata_i;
        end
    end

    // Combinational read; quiet when not selected or writing
    always_comb begin
        if (!cs_n_i && we_n_i) begin
            rdata_o = store[addr_i];
        end else begin
            rdata_o = '0;
        end
    end

endmodule

// File: rtl/bmem_decode.sv
module bmem_decode #(
    parameter int SEL_W = 2,
    parameter int OUT_N = 2 ** SEL_W
) (
    input  logic             en_n_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [OUT_N-1:0] sel_n_o
);
    // One active-low enable per output, all high when disabled
    for (genvar i = 0; i < OUT_N; i++) begin : g_out
        assign sel_n_o[i] = en_n_i | (sel_i != SEL_W'(i));
    end

endmodule

// File: rtl/bmem_rdmux.sv
module bmem_rdmux #(
    parameter int GROUPS = 4,
    parameter int SEL_W  = 2,
    parameter int DW     = 8
) (
    input  logic [GROUPS-1:0][DW-1:0] grp_rd_i,
    input  logic [SEL_W-1:0]          sel_i,
    input  logic                      en_i,
    output logic [DW-1:0]             rdata_o
);
    // Steer the addressed group's word to the output
    always_comb begin
        rdata_o = '0;
        if (en_i) begin
            rdata_o = grp_rd_i[sel_i];
        end
    end

endmodule

// File: rtl/bmem_top.sv
module bmem_top
    import bmem_pkg::*;
#(
    parameter org_e ORG       = ORG_DEPTH,
    parameter int   BANK_AW   = 8,
    parameter int   BANK_DW   = 8,
    parameter int   NUM_BANKS = 4,
    localparam int  LANES     = lanes_of(ORG),
    localparam int  GROUPS    = NUM_BANKS / LANES,
    localparam int  SEL_W     = $clog2(GROUPS),
    localparam int  ADDR_W    = BANK_AW + SEL_W,
    localparam int  DATA_W    = BANK_DW * LANES
) (
    input  logic              clk_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    logic [BANK_AW-1:0]             local_addr;
    logic [SEL_W-1:0]               grp_sel;
    logic [GROUPS-1:0]              grp_sel_n;
    logic [GROUPS-1:0][DATA_W-1:0]  grp_rd;
    logic                           rd_active;

    assign local_addr = addr_i[BANK_AW-1:0];
    assign grp_sel    = addr_i[ADDR_W-1:BANK_AW];
    assign rd_active  = !ce_n_i && we_n_i;

    // Upper address bits pick one bank group
    bmem_decode #(
        .SEL_W (SEL_W),
        .OUT_N (GROUPS)
    ) u_dec (
        .en_n_i  (ce_n_i),
        .sel_i   (grp_sel),
        .sel_n_o (grp_sel_n)
    );

    // Bank array: groups along depth, lanes along width
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            bmem_bank #(
                .AW (BANK_AW),
                .DW (BANK_DW)
            ) u_bank (
                .clk_i   (clk_i),
                .cs_n_i  (grp_sel_n[g]),
                .we_n_i  (we_n_i),
                .addr_i  (local_addr),
                .wdata_i (wdata_i[l*BANK_DW +: BANK_DW]),
                .rdata_o (grp_rd[g][l*BANK_DW +: BANK_DW])
            );
        end
    end

    bmem_rdmux #(
        .GROUPS (GROUPS),
        .SEL_W  (SEL_W),
        .DW     (DATA_W)
    ) u_mux (
        .grp_rd_i (grp_rd),
        .sel_i    (grp_sel),
        .en_i     (rd_active),
        .rdata_o  (rdata_o)
    );

    assign rvalid_o = rd_active;

endmodule

// File: rtl/bmem_top_chk.sv
module bmem_top_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int GROUPS = 4
) (
    input logic              clk_i,
    input logic              ce_n_i,
    input logic              we_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic [GROUPS-1:0] grp_sel_n
);
    // No reset on this block: hold checks off until the first edge
    logic primed = 1'b0;
    always_ff @(posedge clk_i) primed <= 1'b1;

    p_one_group_r2: assert property (@(posedge clk_i) disable iff (!primed)
        !ce_n_i |-> ($countones(~grp_sel_n) == 1));

    p_no_group_idle_r5: assert property (@(posedge clk_i) disable iff (!primed)
        ce_n_i |-> (grp_sel_n == '1));

    p_write_visible_r3: assert property (@(posedge clk_i) disable iff (!primed)
        (!ce_n_i && !we_n_i) |=>
            (!(!ce_n_i && we_n_i && addr_i == $past(addr_i)) || rdata_o == $past(wdata_i)));

    p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!primed)
        ce_n_i |-> (rdata_o == '0 && !rvalid_o));

    p_write_quiet_r6: assert property (@(posedge clk_i) disable iff (!primed)
        (!ce_n_i && !we_n_i) |-> (rdata_o == '0 && !rvalid_o));

    p_read_valid_r7: assert property (@(posedge clk_i) disable iff (!primed)
        (!ce_n_i && we_n_i) |-> rvalid_o);

endmodule

bind bmem_top bmem_top_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GROUPS (GROUPS)
) u_chk (
    .clk_i     (clk_i),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o),
    .grp_sel_n (grp_sel_n)
);

// File: tb/bmem_top_test.sv
module bmem_top_test;
    import bmem_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // Depth-organized instance
    logic        d_ce_n = 1'b1, d_we_n = 1'b1;
    logic [9:0]  d_addr = '0;
    logic [7:0]  d_wdata = '0;
    logic [7:0]  d_rdata;
    logic        d_rvalid;

    // Width-organized instance
    logic        w_ce_n = 1'b1, w_we_n = 1'b1;
    logic [8:0]  w_addr = '0;
    logic [15:0] w_wdata = '0;
    logic [15:0] w_rdata;
    logic        w_rvalid;

    bmem_top #(.ORG(ORG_DEPTH)) uut (
        .clk_i(clk), .ce_n_i(d_ce_n), .we_n_i(d_we_n), .addr_i(d_addr),
        .wdata_i(d_wdata), .rdata_o(d_rdata), .rvalid_o(d_rvalid)
    );

    bmem_top #(.ORG(ORG_WIDTH)) uut_wide (
        .clk_i(clk), .ce_n_i(w_ce_n), .we_n_i(w_we_n), .addr_i(w_addr),
        .wdata_i(w_wdata), .rdata_o(w_rdata), .rvalid_o(w_rvalid)
    );

    logic [7:0]  ref_d [1024];
    logic [15:0] ref_w [512];
    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_d(input int a);
        return 8'((a * 29) + ((a >> 8) * 101) + 5);
    endfunction

    function automatic logic [15:0] pat_w(input int a);
        return 16'((a * 40503) ^ 16'h5A3C);
    endfunction

    // Depth write: checks quiet outputs during the access (R6)
    task automatic d_write(input int a, input logic [7:0] v);
        @(negedge clk);
        d_ce_n = 1'b0; d_we_n = 1'b0; d_addr = 10'(a); d_wdata = v;
        #2;
        chk("R6 depth write rdata", 32'(d_rdata), 32'h0);
        chk("R6 depth write rvalid", 32'(d_rvalid), 32'h0);
        @(posedge clk);
        ref_d[a] = v;
    endtask

    task automatic d_read(input int a, input string req);
        @(negedge clk);
        d_ce_n = 1'b0; d_we_n = 1'b1; d_addr = 10'(a);
        #2;
        chk({req, " R7 depth rvalid"}, 32'(d_rvalid), 32'h1);
        chk({req, " depth rdata"}, 32'(d_rdata), 32'(ref_d[a]));
    endtask

    task automatic w_write(input int a, input logic [15:0] v);
        @(negedge clk);
        w_ce_n = 1'b0; w_we_n = 1'b0; w_addr = 9'(a); w_wdata = v;
        #2;
        chk("R6 width write rdata", 32'(w_rdata), 32'h0);
        @(posedge clk);
        ref_w[a] = v;
    endtask

    task automatic w_read(input int a, input string req);
        @(negedge clk);
        w_ce_n = 1'b0; w_we_n = 1'b1; w_addr = 9'(a);
        #2;
        chk({req, " R7 width rvalid"}, 32'(w_rvalid), 32'h1);
        chk({req, " width rdata"}, 32'(w_rdata), 32'(ref_w[a]));
    endtask

    task automatic t_idle_state;
        @(negedge clk);
        d_ce_n = 1'b1; d_we_n = 1'b1; w_ce_n = 1'b1; w_we_n = 1'b1;
        #2;
        chk("R5 depth idle rdata", 32'(d_rdata), 32'h0);
        chk("R5 depth idle rvalid", 32'(d_rvalid), 32'h0);
        chk("R5 width idle rdata", 32'(w_rdata), 32'h0);
        chk("R5 width idle rvalid", 32'(w_rvalid), 32'h0);
    endtask

    task automatic t_depth_fill;
        for (int a = 0; a < 1024; a++) d_write(a, pat_d(a));
        for (int a = 0; a < 1024; a++) d_read(a, "R1");
    endtask

    task automatic t_alias;
        d_write(205, 8'h11);
        d_write(461, 8'h22);
        d_write(717, 8'h33);
        d_write(973, 8'h44);
        d_read(205, "R2");
        d_read(461, "R2");
        d_read(717, "R2");
        d_read(973, "R2");
    endtask

    task automatic t_boundaries;
        int edges [8] = '{255, 256, 511, 512, 767, 768, 1023, 0};
        for (int i = 0; i < 8; i++) d_write(edges[i], 8'(8'hC0 + i));
        for (int i = 0; i < 8; i++) d_read(edges[i], "R9");
    endtask

    task automatic t_write_then_read;
        d_write(600, 8'h5E);
        d_read(600, "R3");
        d_write(600, 8'hA1);
        d_read(600, "R3");
    endtask

    task automatic t_blocked_write;
        @(negedge clk);
        d_ce_n = 1'b1; d_we_n = 1'b0; d_addr = 10'd300; d_wdata = ~ref_d[300];
        #2;
        chk("R5 disabled rdata", 32'(d_rdata), 32'h0);
        chk("R5 disabled rvalid", 32'(d_rvalid), 32'h0);
        @(posedge clk);
        d_read(300, "R4");
    endtask

    task automatic t_wide;
        for (int a = 0; a < 512; a++) w_write(a, pat_w(a));
        for (int a = 0; a < 512; a++) w_read(a, "R8");
        w_write(255, 16'hA55A);
        w_write(256, 16'h00FF);
        w_write(511, 16'hFF00);
        w_read(255, "R9");
        w_read(256, "R9");
        w_read(511, "R9");
        w_read(0, "R9");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_idle_state();
        t_depth_fill();
        t_alias();
        t_boundaries();
        t_write_then_read();
        t_blocked_write();
        t_wide();
        t_idle_state();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule